// File: doc/BRIEF.md
# Nine-Output Gated Clock Enable Controller

The block takes one input clock and presents it on nine outputs. Each output is a true/complement pair carried as two single-ended signals. Every output has a combined enable: one of six hardware enable pins, ANDed with one bit in a small register file, ANDed with the block's power state. When the combined enable falls, the pair finishes the half period it is in and then parks with both legs low. When the enable rises again, the pair starts again with full-width pulses only.

The six enable pins are fanned out in groups. Pins 0 to 3 each drive one output. Pin 4 drives outputs 4 and 5. Pin 5 drives outputs 6, 7 and 8. The control bits are spread across two register bytes, which are reached through a simple byte-addressed write/read port. A single power-good input starts the block. After its first high level, the same input acts as an active-low power-down.

Enable pins and power input may change at any time. They are brought into the clock domain by a synchronizer. Each gate changes state only while the clock is low.

Top module: `diff_clk_fanout`

## Requirements
- R1: An output runs only when its pin, its register bit, the power-down input (high) and the power-good history are all true. If any one of them is false, the output is parked.
- R2: Pin fan-out by bit of `oe_pin_i`: bits 0..3 drive outputs 0..3, bit 4 drives outputs 4 and 5, bit 5 drives outputs 6, 7 and 8.
- R3: Register port addresses are 0, 1 and 2. A write with `reg_we_i` high takes effect at the rising edge. `reg_rdata_o` shows the addressed byte combinationally. An address of 3 or above reads 0x00, and a write to it changes nothing.
- R4: Register bit map. Address 1: bit 4 controls output 0, bit 2 controls output 1, bit 7 controls output 4, bit 6 controls output 5. Address 2: bit 1 controls output 2, bit 0 controls output 3, bit 5 controls output 6, bit 4 controls output 7, bit 3 controls output 8.
- R5: A parked output holds both `clk_t_o` and `clk_c_o` low. A stop never shortens the high pulse that is in progress on either leg.
- R6: Every high pulse on either leg lasts exactly half an input clock period, including the first pulse after a restart.
- R7: While an output runs, `clk_t_o` is high in the clock's high phase and `clk_c_o` is high in its low phase.
- R8: Until `pwrgd_pd_i` has been seen high once after reset, all outputs stay parked. After that, a low level on `pwrgd_pd_i` parks all outputs, and a high level lets them run again.
- R9: All three register bytes reset to 0xFF. Bits outside the R4 map are plain storage and have no effect on any output.
- R10: A change on any enable input is visible at the outputs within SYNC_STAGES+3 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, distributed to all outputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrgd_pd_i | input | 1 | Power good; after its first high level, active-low power-down |
| oe_pin_i | input | 6 | Grouped hardware enable pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (2) | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the addressed byte |
| clk_t_o | output | 9 | True legs of the nine outputs |
| clk_c_o | output | 9 | Complement legs of the nine outputs |

## Verification
The bench builds the block with its default parameters: SYNC_STAGES of 2 and three register bytes on a 2-bit address. The address port therefore has one value, 3, that lies beyond the register file, and the bench uses it to check the out-of-range read and the ignored write. The short synchronizer keeps every settle window at five cycles. That makes it practical to sweep all 64 pin combinations, clear each mapped bit and each unmapped bit one at a time, and cycle power-down, while a pulse-width monitor watches every edge of all eighteen legs.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int unsigned NUM_OUT  = 9;
  localparam int unsigned NUM_PINS = 6;
  localparam int unsigned BYTE_W   = 8;

  // hardware pin feeding each output
  function automatic int unsigned pin_of(input int unsigned o);
    case (o)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4, 5: return 4;
      default: return 5;
    endcase
  endfunction

  // register byte holding each output's control bit
  function automatic int unsigned byte_of(input int unsigned o);
    case (o)
      0, 1, 4, 5: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int unsigned bit_of(input int unsigned o);
    case (o)
      0: return 4;
      1: return 2;
      2: return 1;
      3: return 0;
      4: return 7;
      5: return 6;
      6: return 5;
      7: return 4;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= {W{RST_V}};
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {W{RST_V}};
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_regs.sv
`timescale 1ns/1ps
module dcf_regs
  import dcf_pkg::*;
#(
  parameter int unsigned N_REGS = 3,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NUM_OUT-1:0] ctrl_o
);
  logic [BYTE_W-1:0] regs_q [N_REGS];
  logic              addr_ok;

  assign addr_ok = 32'(addr_i) < N_REGS;

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[r] <= '1;
      else if (we_i && 32'(addr_i) == r)       regs_q[r] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < N_REGS; r++)
      if (32'(addr_i) == r) rdata_o = regs_q[r];
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_map
    assign ctrl_o[o] = regs_q[byte_of(o)][bit_of(o)];
  end

  // R3: a completed write is visible on the read port while the address holds
  p_write_reads_back_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i && addr_ok) && addr_i == $past(addr_i)) |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/dcf_gate.sv
`timescale 1ns/1ps
module dcf_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic open_o,
  output logic t_o,
  output logic c_o
);
  logic gate_t_q, gate_c_q;

  // true-leg gate moves only while clk is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_t_q <= 1'b0;
    else         gate_t_q <= en_i;
  end

  // complement gate trails by half a period, moving only while ~clk is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_c_q <= 1'b0;
    else         gate_c_q <= gate_t_q;
  end

  assign t_o    = clk_i & gate_t_q;
  assign c_o    = ~clk_i & gate_c_q;
  assign open_o = gate_t_q;

  // R5: the complement leg closes after the true leg, finishing its phase
  p_c_closes_after_t_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_t_q) |-> gate_c_q);
endmodule

// File: rtl/diff_clk_fanout.sv
`timescale 1ns/1ps
module diff_clk_fanout
  import dcf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_REGS      = 3,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrgd_pd_i,
  input  logic [5:0]        oe_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [8:0]        clk_t_o,
  output logic [8:0]        clk_c_o
);
  logic [NUM_PINS-1:0] pin_s;
  logic                pwr_s;
  logic                seen_q;
  logic                pwr_ok;
  logic [NUM_OUT-1:0]  ctrl;
  logic [NUM_OUT-1:0]  en_vec;
  logic [NUM_OUT-1:0]  gate_open;

  dcf_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_pin_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(oe_pin_i), .q_o(pin_s)
  );

  dcf_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_V(1'b0)) u_pwr_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pwrgd_pd_i), .q_o(pwr_s)
  );

  // first power-good arms the block; afterwards the pin is a live power-down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_q <= 1'b0;
    else if (pwr_s) seen_q <= 1'b1;
  end

  assign pwr_ok = pwr_s & seen_q;

  dcf_regs #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .ctrl_o (ctrl)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    assign en_vec[o] = pin_s[pin_of(o)] & ctrl[o] & pwr_ok;

    dcf_gate u_gate (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_vec[o]),
      .open_o(gate_open[o]),
      .t_o   (clk_t_o[o]),
      .c_o   (clk_c_o[o])
    );
  end

  // R1: each true gate reflects the combined enable of the preceding cycle
  p_gate_tracks_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_open == en_vec);

  // R8: no gate is open while power is not good
  p_pd_parks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok |-> gate_open == '0);

  // R8: once armed, the block stays armed until reset
  p_seen_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> seen_q);
endmodule

// File: tb/diff_clk_fanout_tb.sv
`timescale 1ns/1ps
module diff_clk_fanout_tb;
  localparam int unsigned SYNC = 2;
  localparam int unsigned SETTLE = SYNC + 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwrgd_pd_i = 1'b0;
  logic [5:0] oe_pin_i = '1;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [8:0] clk_t_o, clk_c_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [8:0] mask; string tag; } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #5ns clk_i = ~clk_i;

  diff_clk_fanout #(.SYNC_STAGES(SYNC)) u_dut (.*);

  function automatic logic [8:0] exp_mask(logic [5:0] p, logic [7:0] b1, logic [7:0] b2, logic pg);
    logic [8:0] grp, bits;
    grp  = {p[5], p[5], p[5], p[4], p[4], p[3], p[2], p[1], p[0]};
    bits = {b2[3], b2[4], b2[5], b1[6], b1[7], b2[0], b2[1], b1[2], b1[4]};
    return pg ? (grp & bits) : 9'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv, string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // R6/R5: pulse width monitor on every leg
  for (genvar g = 0; g < 9; g++) begin : g_mon
    realtime t_rise, c_rise;
    always @(posedge clk_t_o[g]) t_rise = $realtime;
    always @(posedge clk_c_o[g]) c_rise = $realtime;
    always @(negedge clk_t_o[g]) if (rst_ni) begin
      checks++;
      if ($realtime - t_rise != 5.0) begin
        errors++;
        $display("FAIL R6 true leg %0d pulse: actual %0t expected 5ns", g, $realtime - t_rise);
      end
    end
    always @(negedge clk_c_o[g]) if (rst_ni) begin
      checks++;
      if ($realtime - c_rise != 5.0) begin
        errors++;
        $display("FAIL R6 complement leg %0d pulse: actual %0t expected 5ns", g, $realtime - c_rise);
      end
    end
  end

  // monitor: pops expectations and samples both phases (R7, R5)
  initial forever begin
    exp_t e;
    @(chk_ev);
    e = exp_q.pop_front();
    @(posedge clk_i); #2ns;
    check(e.tag, 32'(clk_t_o), 32'(e.mask), "true legs, high phase");
    check(e.tag, 32'(clk_c_o), 32'h0, "complement legs, high phase");
    @(negedge clk_i); #2ns;
    check(e.tag, 32'(clk_t_o), 32'h0, "true legs, low phase");
    check(e.tag, 32'(clk_c_o), 32'(e.mask), "complement legs, low phase");
  end

  logic [7:0] b1_m = 8'hFF, b2_m = 8'hFF;
  logic       armed = 1'b0;

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] expv, string req);
    @(negedge clk_i);
    reg_addr_i = a;
    #1ns;
    check(req, 32'(reg_rdata_o), 32'(expv), $sformatf("read addr %0d", a));
  endtask

  // driver: applies stimulus, waits the R10 bound, pushes expectation
  task automatic apply(logic [5:0] p, logic [7:0] b1, logic [7:0] b2, logic pg, string tag);
    exp_t e;
    if (b1 != b1_m) begin wr(2'd1, b1); b1_m = b1; end
    if (b2 != b2_m) begin wr(2'd2, b2); b2_m = b2; end
    #3ns;
    oe_pin_i = p;
    pwrgd_pd_i = pg;
    if (pg) armed = 1'b1;
    repeat (SETTLE) @(posedge clk_i);
    e.mask = exp_mask(p, b1, b2, pg & armed);
    e.tag  = {tag, " R10"};
    exp_q.push_back(e);
    ->chk_ev;
    repeat (3) @(posedge clk_i);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2ns;
    check("R5", 32'({clk_t_o, clk_c_o}), 32'h0, "parked during reset");
    rst_ni = 1'b1;
    // R9: reset values
    rd(2'd0, 8'hFF, "R9");
    rd(2'd1, 8'hFF, "R9");
    rd(2'd2, 8'hFF, "R9");
    // R8: nothing runs before the first power-good
    apply(6'h3F, 8'hFF, 8'hFF, 1'b0, "R8 before power good");
    apply(6'h3F, 8'hFF, 8'hFF, 1'b1, "R8 first power good, R9 default all run");
    // R3: register port
    wr(2'd0, 8'h5A);
    rd(2'd0, 8'h5A, "R3");
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00, "R3 out of range");
    rd(2'd1, 8'hFF, "R3 no alias from addr 3");
    rd(2'd2, 8'hFF, "R3 no alias from addr 3");
    apply(6'h3F, 8'hFF, 8'hFF, 1'b1, "R3 ignored write has no effect");
    // R2/R1: every pin combination
    for (int p = 0; p < 64; p++) apply(6'(p), 8'hFF, 8'hFF, 1'b1, "R2 pin sweep R1");
    // R4: clear each mapped bit alone
    foreach (exp_q[i]) ;
    for (int b = 0; b < 8; b++) apply(6'h3F, ~(8'h1 << b), 8'hFF, 1'b1, "R4 byte1 bit");
    for (int b = 0; b < 8; b++) apply(6'h3F, 8'hFF, ~(8'h1 << b), 1'b1, "R4 byte2 bit");
    // R9: unmapped bits and byte 0 have no effect
    wr(2'd0, 8'h00);
    apply(6'h3F, 8'h14 | 8'hC0, 8'h3B, 1'b1, "R9 unmapped bits cleared");
    // R1: mixed pin and bit patterns
    apply(6'h2A, 8'h50, 8'h29, 1'b1, "R1 mix a");
    apply(6'h15, 8'hD4, 8'h3B, 1'b1, "R1 mix b");
    apply(6'h1E, 8'h84, 8'h12, 1'b1, "R1 mix c");
    // R8: live power-down and recovery
    apply(6'h3F, 8'hFF, 8'hFF, 1'b0, "R8 power down");
    apply(6'h3F, 8'hFF, 8'hFF, 1'b1, "R8 power restored");
    // R5/R6: rapid stop and restart on one group
    apply(6'h1F, 8'hFF, 8'hFF, 1'b1, "R5 stop group 6-8");
    apply(6'h3F, 8'hFF, 8'hFF, 1'b1, "R6 restart group 6-8");
    repeat (5) @(posedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule